// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit works out the 24-bit memory address for one operand of a small microcontroller core. The decoder gives it a mode code and a base register selector, along with the base register value, a data register used as an index, an immediate field, the program counter and the operand size. From these the unit returns the effective address. For indirect modes it also raises a flag telling the core to fetch a 24-bit pointer from that address. For auto-modify modes it returns the updated pointer register value and a write-back enable.

Each mode accepts only certain base registers, and the stack pointer accepts only two of the four auto-modify forms. Any pairing outside these rules raises an error output. On error the address and write-back outputs are forced to zero. The unit is combinational by default. A parameter adds one output register stage.

Top module: `addr_gen_unit`

## Requirements
- R1: Mode 0 (absolute direct) and mode 1 (absolute indirect) give eaOut = immVal. Mode 1 also sets indFlag. The unit checks no base register in these modes.
- R2: Mode 2 (constant-offset direct) accepts baseSel 0..7 (data registers), 8 (X), 9 (Y), 10 (S) and 11 (PC). Mode 3 (constant-offset indirect, which sets indFlag) accepts only 8..11. The address is base + immVal. For baseSel 11 the base is pcVal; otherwise it is baseVal.
- R3: In mode 4 (register-offset direct) and mode 5 (register-offset indirect), the address is baseVal plus the low IW bits of idxVal. Those bits are sign-extended when idxSel is 2..5 and zero-extended when idxSel is 0, 1, 6 or 7. Mode 5 sets indFlag.
- R4: Mode 4 accepts baseSel 8, 9 or 10. Mode 5 accepts only 8 or 9.
- R5: Mode 6 (PC-relative) gives pcVal plus immVal[15:0], sign-extended.
- R6: The auto-modify step is opSize+1: code 0 steps by 1 (byte), 1 by 2 (word), 2 by 3 (pointer) and 3 by 4 (long).
- R7: Modes 7 (pre-increment) and 8 (pre-decrement) output the modified value as the address. Modes 9 (post-increment) and 10 (post-decrement) output the original baseVal. In all four modes wbVal holds the modified value.
- R8: Auto-modify on X or Y allows all four forms. On S (baseSel 10) only modes 8 and 9 are legal. Any other base raises errFlag.
- R9: wbEn is 1 only for a legal auto-modify operation. When wbEn is 0, wbVal is 0.
- R10: Mode codes 11..15 and illegal pairings set errFlag, and then eaOut = 0, indFlag = 0 and wbEn = 0.
- R11: All address arithmetic wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rstN | input | 1 | Active-low reset |
| modeSel | input | 4 | Addressing mode code |
| baseSel | input | 4 | Base selector: 0..7 data, 8 X, 9 Y, 10 S, 11 PC |
| idxSel | input | 3 | Number of the data register used as index |
| baseVal | input | 24 | Value of the selected base register |
| idxVal | input | 16 | Index data register value (low IW bits) |
| immVal | input | 24 | Immediate offset, absolute address or displacement |
| pcVal | input | 24 | Program counter |
| opSize | input | 2 | Operand size code |
| eaOut | output | 24 | Effective or pointer address |
| indFlag | output | 1 | A second pointer fetch is needed |
| wbVal | output | 24 | Updated base register value |
| wbEn | output | 1 | Write back wbVal |
| errFlag | output | 1 | Illegal mode or register pairing |

## Verification
The bench targets address wrap at 0x000000 and 0xFFFFFF in both step directions. A unit that carries past 24 bits or drops the borrow gives the wrong address or write-back value there. It also compares an index of 0x8000 taken from D3 with the same value from D6. Getting signedness wrong moves the address by 64 KiB. The bench drives S with the two forbidden auto-modify forms and feeds unsupported bases to the indirect modes; a unit that fails to flag these writes back a pointer it should not. Swapping pre and post order returns the base register one step off, and the bench checks each of the four forms for this.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [3:0] {
    M_ABS      = 4'd0,
    M_ABS_IND  = 4'd1,
    M_COFF     = 4'd2,
    M_COFF_IND = 4'd3,
    M_ROFF     = 4'd4,
    M_ROFF_IND = 4'd5,
    M_PCREL    = 4'd6,
    M_PREINC   = 4'd7,
    M_PREDEC   = 4'd8,
    M_POSTINC  = 4'd9,
    M_POSTDEC  = 4'd10
  } modeE;

  localparam logic [3:0] SEL_X = 4'd8;
  localparam logic [3:0] SEL_Y = 4'd9;
  localparam logic [3:0] SEL_S = 4'd10;
  localparam logic [3:0] SEL_P = 4'd11;

  typedef struct packed {
    logic useBase;
    logic usePc;
    logic addImm;
    logic addIdx;
    logic idxSigned;
    logic pcRel;
    logic stepEn;
    logic stepNeg;
    logic preMod;
    logic ind;
    logic wb;
    logic err;
  } strobeT;

endpackage

// File: rtl/eau_ctrl.sv
module eau_ctrl
  import eau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] modeSel,
  input  logic [3:0] baseSel,
  input  logic [2:0] idxSel,
  output strobeT     stb
);

  logic isXY, isXYS, isPtr, isData, legal;
  strobeT raw;

  assign isXY   = (baseSel == SEL_X) || (baseSel == SEL_Y);
  assign isXYS  = isXY || (baseSel == SEL_S);
  assign isPtr  = isXYS || (baseSel == SEL_P);
  assign isData = (baseSel < 4'd8);

  always_comb begin
    raw   = '0;
    legal = 1'b1;
    case (modeSel)
      M_ABS:      raw.addImm = 1'b1;
      M_ABS_IND: begin
        raw.addImm = 1'b1;
        raw.ind    = 1'b1;
      end
      M_COFF, M_COFF_IND: begin
        legal       = (modeSel == M_COFF) ? (isPtr || isData) : isPtr;
        raw.addImm  = 1'b1;
        raw.usePc   = (baseSel == SEL_P);
        raw.useBase = (baseSel != SEL_P);
        raw.ind     = (modeSel == M_COFF_IND);
      end
      M_ROFF, M_ROFF_IND: begin
        legal         = (modeSel == M_ROFF) ? isXYS : isXY;
        raw.useBase   = 1'b1;
        raw.addIdx    = 1'b1;
        raw.idxSigned = (idxSel >= 3'd2) && (idxSel <= 3'd5);
        raw.ind       = (modeSel == M_ROFF_IND);
      end
      M_PCREL: begin
        raw.usePc = 1'b1;
        raw.pcRel = 1'b1;
      end
      M_PREINC, M_PREDEC, M_POSTINC, M_POSTDEC: begin
        legal = ((modeSel == M_PREDEC) || (modeSel == M_POSTINC)) ? isXYS : isXY;
        raw.useBase = 1'b1;
        raw.stepEn  = 1'b1;
        raw.wb      = 1'b1;
        raw.stepNeg = (modeSel == M_PREDEC) || (modeSel == M_POSTDEC);
        raw.preMod  = (modeSel == M_PREINC) || (modeSel == M_PREDEC);
      end
      default: legal = 1'b0;
    endcase
    if (legal) begin
      stb = raw;
    end else begin
      stb     = '0;
      stb.err = 1'b1;
    end
  end

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    stb.err |-> (!stb.wb && !stb.ind)); // R10
  AST_ONE_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.addImm, stb.addIdx, stb.pcRel, stb.stepEn})); // R2
  AST_S_AUTO_FORMS: assert property (@(posedge clk) disable iff (!rstN)
    (baseSel == SEL_S && stb.stepEn) |-> (stb.stepNeg == stb.preMod)); // R8

endmodule

// File: rtl/eau_dp.sv
module eau_dp
  import eau_pkg::*;
#(
  parameter int AW = 24,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [AW-1:0] baseVal,
  input  logic [IW-1:0] idxVal,
  input  logic [AW-1:0] immVal,
  input  logic [AW-1:0] pcVal,
  input  logic [1:0]    opSize,
  output logic [AW-1:0] eaRaw,
  output logic [AW-1:0] wbRaw
);

  localparam int DW = 16;

  logic [AW-1:0] step, idxExt, dispExt, baseOp, offOp, sum;

  assign step    = AW'(opSize) + AW'(1);
  assign idxExt  = stb.idxSigned ? {{(AW-IW){idxVal[IW-1]}}, idxVal}
                                 : {{(AW-IW){1'b0}}, idxVal};
  assign dispExt = {{(AW-DW){immVal[DW-1]}}, immVal[DW-1:0]};

  always_comb begin
    if (stb.usePc)        baseOp = pcVal;
    else if (stb.useBase) baseOp = baseVal;
    else                  baseOp = '0;

    if (stb.addImm)       offOp = immVal;
    else if (stb.addIdx)  offOp = idxExt;
    else if (stb.pcRel)   offOp = dispExt;
    else if (stb.stepEn)  offOp = stb.stepNeg ? (~step + AW'(1)) : step;
    else                  offOp = '0;
  end

  assign sum   = baseOp + offOp;
  assign eaRaw = stb.err ? '0 : ((stb.stepEn && !stb.preMod) ? baseOp : sum);
  assign wbRaw = stb.wb ? sum : '0;

  AST_PRE_USES_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wb && stb.preMod) |-> (eaRaw == wbRaw)); // R7
  AST_POST_USES_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wb && !stb.preMod) |-> (eaRaw == baseVal)); // R7
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wb |-> ((AW'(wbRaw - baseVal) == AW'(opSize) + AW'(1)) ||
                (AW'(baseVal - wbRaw) == AW'(opSize) + AW'(1)))); // R6

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import eau_pkg::*;
#(
  parameter int AW      = 24,
  parameter int IW      = 16,
  parameter bit REG_OUT = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    modeSel,
  input  logic [3:0]    baseSel,
  input  logic [2:0]    idxSel,
  input  logic [AW-1:0] baseVal,
  input  logic [IW-1:0] idxVal,
  input  logic [AW-1:0] immVal,
  input  logic [AW-1:0] pcVal,
  input  logic [1:0]    opSize,
  output logic [AW-1:0] eaOut,
  output logic          indFlag,
  output logic [AW-1:0] wbVal,
  output logic          wbEn,
  output logic          errFlag
);

  strobeT stb;
  logic [AW-1:0] eaRaw, wbRaw;

  eau_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .baseSel(baseSel),
    .idxSel(idxSel), .stb(stb)
  );

  eau_dp #(.AW(AW), .IW(IW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .baseVal(baseVal), .idxVal(idxVal),
    .immVal(immVal), .pcVal(pcVal), .opSize(opSize),
    .eaRaw(eaRaw), .wbRaw(wbRaw)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          eaOut   <= '0;
          indFlag <= 1'b0;
          wbVal   <= '0;
          wbEn    <= 1'b0;
          errFlag <= 1'b0;
        end else begin
          eaOut   <= eaRaw;
          indFlag <= stb.ind;
          wbVal   <= wbRaw;
          wbEn    <= stb.wb;
          errFlag <= stb.err;
        end
      end
    end else begin : g_comb
      assign eaOut   = eaRaw;
      assign indFlag = stb.ind;
      assign wbVal   = wbRaw;
      assign wbEn    = stb.wb;
      assign errFlag = stb.err;
    end
  endgenerate

  AST_WB_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> !errFlag); // R9
  AST_WB_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !wbEn |-> (wbVal == '0)); // R9
  AST_ERR_ZERO_EA: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (eaOut == '0 && !indFlag)); // R10

endmodule

// File: tb/addr_gen_unit_tb.sv
module addr_gen_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] ea;
    logic        ind;
    logic [23:0] wbv;
    logic        wb;
    logic        err;
  } expT;

  logic clk = 1'b0, rstN = 1'b0;
  logic [3:0] modeSel = '0, baseSel = '0;
  logic [2:0] idxSel = '0;
  logic [23:0] baseVal = '0, immVal = '0, pcVal = '0;
  logic [15:0] idxVal = '0;
  logic [1:0] opSize = '0;
  logic [23:0] eaOut, wbVal;
  logic indFlag, wbEn, errFlag;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen_unit dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .baseSel(baseSel),
    .idxSel(idxSel), .baseVal(baseVal), .idxVal(idxVal), .immVal(immVal),
    .pcVal(pcVal), .opSize(opSize), .eaOut(eaOut), .indFlag(indFlag),
    .wbVal(wbVal), .wbEn(wbEn), .errFlag(errFlag)
  );

  function automatic expT model(input int m, input int b, input int ix,
                                input logic [23:0] bv, input logic [15:0] iv,
                                input logic [23:0] im, input logic [23:0] pc,
                                input int sz);
    expT r;
    logic [23:0] base, off, nv;
    bit ok;
    r = '0;
    ok = 1'b0;
    base = (b == 11) ? pc : bv;
    if (m == 0 || m == 1) begin
      ok = 1'b1; r.ea = im; r.ind = (m == 1);
    end else if (m == 2 || m == 3) begin
      ok = (m == 2) ? (b <= 11) : (b >= 8 && b <= 11);
      r.ea = base + im; r.ind = (m == 3);
    end else if (m == 4 || m == 5) begin
      ok = (m == 4) ? (b >= 8 && b <= 10) : (b == 8 || b == 9);
      off = (ix >= 2 && ix <= 5) ? 24'(signed'(iv)) : {8'h00, iv};
      r.ea = bv + off; r.ind = (m == 5);
    end else if (m == 6) begin
      ok = 1'b1; r.ea = pc + 24'(signed'(im[15:0]));
    end else if (m >= 7 && m <= 10) begin
      ok = (b == 8 || b == 9) || (b == 10 && (m == 8 || m == 9));
      nv = (m == 7 || m == 9) ? bv + 24'(sz + 1) : bv - 24'(sz + 1);
      r.ea = (m <= 8) ? nv : bv;
      r.wb = 1'b1; r.wbv = nv;
    end
    if (!ok) begin
      r = '0; r.err = 1'b1;
    end
    return r;
  endfunction

  task automatic apply(input int m, input int b, input int ix,
                       input logic [23:0] bv, input logic [15:0] iv,
                       input logic [23:0] im, input logic [23:0] pc,
                       input int sz, input string tag);
    expT e, a;
    @(negedge clk);
    modeSel = 4'(m); baseSel = 4'(b); idxSel = 3'(ix);
    baseVal = bv; idxVal = iv; immVal = im; pcVal = pc; opSize = 2'(sz);
    #2;
    e = model(m, b, ix, bv, iv, im, pc, sz);
    a = '{eaOut, indFlag, wbVal, wbEn, errFlag};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s mode=%0d base=%0d: got ea=%h ind=%b wbv=%h wb=%b err=%b expected ea=%h ind=%b wbv=%h wb=%b err=%b",
               tag, m, b, a.ea, a.ind, a.wbv, a.wb, a.err,
               e.ea, e.ind, e.wbv, e.wb, e.err);
    end
  endtask

  function automatic string tagOf(input int m, input int b);
    if (m >= 11) return "R10";
    if (m <= 1)  return "R1";
    if (m <= 3)  return "R2";
    if (m <= 5)  return "R3";
    if (m == 6)  return "R5";
    if (b == 10) return "R8";
    return "R7";
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    checks++;
    if (eaOut !== 24'h0 || errFlag !== 1'b0 || wbEn !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ea=%h err=%b wb=%b expected 000000 0 0", eaOut, errFlag, wbEn);
    end
    rstN = 1'b1;

    apply(0, 3, 0, 24'h111111, 16'h0, 24'hFE0034, 24'h0, 0, "R1");
    apply(1, 15, 0, 24'h0, 16'h0, 24'hFD0012, 24'h0, 0, "R1");
    apply(2, 11, 0, 24'h0, 16'h0, 24'h000010, 24'h400000, 0, "R2");
    apply(2, 0, 0, 24'h00FFFF, 16'h0, 24'h00002D, 24'h0, 0, "R2");
    apply(3, 0, 0, 24'h001000, 16'h0, 24'h4, 24'h0, 0, "R2");
    apply(2, 8, 0, 24'hFFFFF0, 16'h0, 24'h000020, 24'h0, 0, "R11");
    apply(4, 8, 3, 24'h000010, 16'h8000, 24'h0, 24'h0, 0, "R3");
    apply(4, 8, 6, 24'h000010, 16'h8000, 24'h0, 24'h0, 0, "R3");
    apply(5, 9, 1, 24'h000100, 16'hFFFF, 24'h0, 24'h0, 0, "R3");
    apply(4, 11, 0, 24'h000100, 16'h1, 24'h0, 24'h0, 0, "R4");
    apply(5, 10, 0, 24'h000100, 16'h1, 24'h0, 24'h0, 0, "R4");
    apply(6, 0, 0, 24'h0, 16'h0, 24'h00FFCF, 24'h000020, 0, "R5");
    apply(6, 0, 0, 24'h0, 16'h0, 24'h007FFF, 24'hFFFFF0, 0, "R5");
    apply(7, 8, 0, 24'hFFFFFF, 16'h0, 24'h0, 24'h0, 3, "R6");
    apply(10, 9, 0, 24'h000000, 16'h0, 24'h0, 24'h0, 0, "R11");
    apply(9, 8, 0, 24'h000500, 16'h0, 24'h0, 24'h0, 2, "R7");
    apply(8, 10, 0, 24'h000002, 16'h0, 24'h0, 24'h0, 2, "R7");
    apply(7, 10, 0, 24'h000500, 16'h0, 24'h0, 24'h0, 0, "R8");
    apply(10, 10, 0, 24'h000500, 16'h0, 24'h0, 24'h0, 0, "R8");
    apply(9, 10, 0, 24'hFFFFFE, 16'h0, 24'h0, 24'h0, 1, "R8");
    apply(8, 3, 0, 24'h000500, 16'h0, 24'h0, 24'h0, 1, "R9");
    apply(12, 8, 0, 24'h000500, 16'h0, 24'h5, 24'h0, 0, "R10");
    apply(2, 13, 0, 24'h000500, 16'h0, 24'h5, 24'h0, 0, "R10");

    for (int i = 0; i < 3000; i++) begin
      int m, b;
      m = (i % 4 == 0) ? int'($urandom_range(15, 0)) : int'($urandom_range(10, 0));
      b = int'($urandom_range(15, 0));
      apply(m, b, int'($urandom_range(7, 0)), 24'($urandom), 16'($urandom),
            24'($urandom), 24'($urandom), int'($urandom_range(3, 0)), tagOf(m, b));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule